// File: doc/BRIEF.md
# Vertical Polyphase Row Resampler

This block is the vertical half of a separable video scaler. Input pixels arrive in raster order and are written into a four-row circular line buffer. Each row slot holds up to `MAX_W` pixels. For every output row the block works out a 16.16 fixed-point source position. Its integer part picks the centre row n, and its top fractional bits pick one of 16 phases. The block then walks the buffered rows column by column. Each column is filtered as a 4-tap cubic kernel over rows n-1, n, n+1 and n+2, using a coefficient set chosen by the phase.

One filtered value leaves per column as an unrounded 20-bit signed sum, with a valid strobe. It is meant to feed a horizontal filter stage. Upscaling, downscaling and unity ratios all use the same datapath; only the step value and the output row count differ. When an input row would overwrite a buffer slot that the pending output row still needs, the block holds off input with `in_ready`. When a frame is finished on both sides, the block re-arms by itself for the next frame.

Top module: `vpoly_filter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Input pixel r,c (row r, column c) is stored in slot r mod 4. `in_ready` is held low whenever accepting the next pixel would overwrite a row that the pending output row still needs. Because of this, no output is ever computed from an overwritten row.
- R3: With a step of 0x0001_0000, output row k equals 256 times input row k, pixel for pixel.
- R4: For phase p (0..15), the weights for rows n-1, n, n+1, n+2 are defined as follows. Each division truncates toward zero.
  - w0 = (-p³ + 32p² - 256p)/32
  - w3 = (p³ - 16p²)/32
  - w2 = (-3p³ + 64p² + 256p)/32
  - w1 = 256 - w0 - w2 - w3

  The output is the plain sum of pixel times weight, with pixels taken as unsigned.
- R5: The phase is bits 15:12 of the row position. Bits 11:0 do not affect the weights, but they do carry into later positions.
- R6: Output row k uses position k·step modulo 2^32. Its centre row n is bits 31:16 of that position.
- R7: A source row index below 0 reads row 0. An index above `cfg_in_rows`-1 reads the last row.
- R8: Every output row emits exactly `cfg_cols` valid pixels, from column 0 upward. Rows come out in order, and no valid strobe appears beyond `cfg_out_rows` rows.
- R9: With a step above 1.0 (downscaling), rows are skipped. Positions past the last input row read the clamped last row.
- R10: Once all `cfg_in_rows` rows have been accepted and all `cfg_out_rows` rows emitted, the block re-arms and `in_ready` returns high. Configuration may change only while the block is re-armed.
- R11: Row widths from 1 up to `MAX_W` pixels are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | $clog2(MAX_W+1) | Pixels per row (1..MAX_W) |
| cfg_in_rows | input | ROW_W | Input rows per frame (at least 1) |
| cfg_out_rows | input | ROW_W | Output rows per frame |
| cfg_step | input | 32 | Source row advance per output row, 16.16 fixed point |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | PIX_W | Input pixel, unsigned |
| in_ready | output | 1 | Block can take an input pixel this cycle |
| out_valid | output | 1 | Filtered pixel present |
| out_data | output | ACC_W | Filtered pixel, signed and unrounded |

## Verification
A unity step checks that the centre-tap weight and the slot addressing are right without any blending. A half step alternates phases 0 and 8, so it separates the kernel weights and exercises clamping at the bottom edge under input stalls. A step with set low fraction bits shows that those bits shift later phases but never enter the weight choice. Steps of two and three check row skipping and positions past the frame end. A full-width frame with a 0.6875 step covers the widest row and odd phases. Back-to-back frames with changing sizes check the re-arm behaviour.

// File: rtl/vpoly_filter.sv
module vpoly_filter #(
  parameter int PIX_W      = 8,
  parameter int COEF_W     = 10,
  parameter int ACC_W      = 20,
  parameter int MAX_W      = 64,
  parameter int PHASE_BITS = 4,
  parameter int ROW_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(MAX_W+1)-1:0] cfg_cols,
  input  logic [ROW_W-1:0]           cfg_in_rows,
  input  logic [ROW_W-1:0]           cfg_out_rows,
  input  logic [31:0]                cfg_step,
  input  logic                       in_valid,
  input  logic [PIX_W-1:0]           in_pix,
  output logic                       in_ready,
  output logic                       out_valid,
  output logic signed [ACC_W-1:0]    out_data
);
  localparam int TAPS   = 4;
  localparam int SLOT_W = 2;
  localparam int PH     = 1 << PHASE_BITS;
  localparam int CW     = $clog2(MAX_W + 1);
  localparam int AW     = $clog2(TAPS * MAX_W);

  // cubic kernel scaled to a sum of 256, truncating divisions
  function automatic int kern(int p, int t);
    int d, a, b, c;
    d = PH * PH * PH;
    a = (-p*p*p + 2*p*p*PH - p*PH*PH) * 128 / d;
    c = (-3*p*p*p + 4*p*p*PH + p*PH*PH) * 128 / d;
    b = (p*p*p - p*p*PH) * 128 / d;
    case (t)
      0:       return a;
      2:       return c;
      3:       return b;
      default: return 256 - a - b - c;
    endcase
  endfunction

  logic signed [COEF_W-1:0] coef_rom [PH][TAPS];
  for (genvar p = 0; p < PH; p++) begin : g_ph
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign coef_rom[p][t] = COEF_W'(kern(p, t));
    end
  end

  logic [PIX_W-1:0] mem [TAPS*MAX_W];
  logic [ROW_W-1:0] wr_row, out_cnt;
  logic [CW-1:0]    wr_col, rd_col;
  logic [31:0]      pos;
  logic             busy;
  logic [ROW_W-1:0] tap_row [TAPS];
  int               acc;

  wire [PHASE_BITS-1:0] phase = pos[15 -: PHASE_BITS];
  wire out_done = (out_cnt == cfg_out_rows);

  always_comb begin
    int r;
    for (int t = 0; t < TAPS; t++) begin
      r = int'(pos[31:16]) + t - 1;
      if (r < 0) r = 0;
      if (r > int'(cfg_in_rows) - 1) r = int'(cfg_in_rows) - 1;
      tap_row[t] = r[ROW_W-1:0];
    end
  end

  assign in_ready = (wr_row < cfg_in_rows) &&
                    (out_done || ({1'b0, wr_row} < {1'b0, tap_row[0]} + (ROW_W+1)'(TAPS)));
  wire wr_fire = in_valid && in_ready;
  wire start   = !busy && !out_done && (tap_row[TAPS-1] < wr_row);
  wire rearm   = !busy && out_done && (wr_row == cfg_in_rows);
  wire rd_last = (rd_col == cfg_cols - CW'(1));
  wire wr_last = (wr_col == cfg_cols - CW'(1));

  always_ff @(posedge clk)
    if (wr_fire)
      mem[AW'(int'(wr_row[SLOT_W-1:0]) * MAX_W + int'(wr_col))] <= in_pix;

  always_comb begin
    acc = 0;
    for (int t = 0; t < TAPS; t++)
      acc += int'(mem[AW'(int'(tap_row[t][SLOT_W-1:0]) * MAX_W + int'(rd_col))]) *
             int'(coef_rom[phase][t]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_row    <= '0;
      wr_col    <= '0;
      rd_col    <= '0;
      out_cnt   <= '0;
      pos       <= '0;
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= busy;
      out_data  <= acc[ACC_W-1:0];
      if (wr_fire) begin
        if (wr_last) begin
          wr_col <= '0;
          wr_row <= wr_row + 1'b1;
        end else begin
          wr_col <= wr_col + 1'b1;
        end
      end
      if (start) begin
        busy   <= 1'b1;
        rd_col <= '0;
      end else if (busy) begin
        if (rd_last) begin
          busy    <= 1'b0;
          pos     <= pos + cfg_step;
          out_cnt <= out_cnt + 1'b1;
        end else begin
          rd_col <= rd_col + 1'b1;
        end
      end
      if (rearm) begin
        wr_row  <= '0;
        wr_col  <= '0;
        out_cnt <= '0;
        pos     <= '0;
      end
    end
  end

  // R2: a write never lands in a slot that the running output row reads
  p_no_slot_clash_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_fire) |-> ((wr_row > tap_row[TAPS-1]) &&
                           ({1'b0, wr_row} < {1'b0, tap_row[0]} + (ROW_W+1)'(TAPS))));

  // R2: only fully written rows are read
  p_rows_complete_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tap_row[TAPS-1] < wr_row));

  // R5: phase and centre row stay fixed across an output row
  p_phase_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pos));

  // R8: no more output rows than configured
  p_row_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= cfg_out_rows);

  // R10: the write side never runs past the frame
  p_wr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_row <= cfg_in_rows);

  // R8: each output pixel comes from a read cycle
  p_out_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
endmodule

// File: tb/sim_vpoly_filter.sv
module sim_vpoly_filter;
  localparam int MAX_W = 64;
  localparam int CW    = $clog2(MAX_W + 1);

  logic        clk = 0;
  logic        rst_n = 0;
  logic [CW-1:0] cfg_cols = 8;
  logic [15:0] cfg_in_rows = 6, cfg_out_rows = 6;
  logic [31:0] cfg_step = 32'h0001_0000;
  logic        in_valid = 0;
  logic [7:0]  in_pix = 0;
  logic        in_ready, out_valid;
  logic signed [19:0] out_data;

  int n_tests = 0, n_fail = 0, cycles = 0;
  int exp_q[$];
  string cur_tag = "R8";

  always #2.5 clk = ~clk;

  vpoly_filter u0 (.clk, .rst_n, .cfg_cols, .cfg_in_rows, .cfg_out_rows, .cfg_step,
                   .in_valid, .in_pix, .in_ready, .out_valid, .out_data);

  function automatic int pix(int f, int r, int c);
    if (c == 0) return 255;
    if (c == 1) return 0;
    return ((r * 67 + c * 29 + f * 13) ^ (c << 3)) & 255;
  endfunction

  // R4 weight table, written for 16 phases
  function automatic int wgt(int p, int t);
    int a, b, c;
    a = (-p*p*p + 32*p*p - 256*p) / 32;
    b = (p*p*p - 16*p*p) / 32;
    c = (-3*p*p*p + 64*p*p + 256*p) / 32;
    if (t == 0) return a;
    if (t == 2) return c;
    if (t == 3) return b;
    return 256 - a - b - c;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check(0, "R8 extra output", int'(out_data), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(out_data) == e, cur_tag, int'(out_data), e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_frame(int f, int cols, int rows, int orows, logic [31:0] step, string tag);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R10: re-armed after the previous frame
    check(in_ready == 1'b1, "R10 re-arm", int'(in_ready), 1);
    cfg_cols = CW'(cols); cfg_in_rows = 16'(rows); cfg_out_rows = 16'(orows);
    cfg_step = step; cur_tag = tag;
    // R6: row k at k*step, centre row from bits 31:16, phase from 15:12 (R5)
    for (int k = 0; k < orows; k++) begin
      logic [31:0] p32;
      int n, ph;
      p32 = 32'(k) * step;
      n = int'(p32[31:16]);
      ph = int'(p32[15:12]);
      for (int c = 0; c < cols; c++) begin
        int s;
        s = 0;
        for (int t = 0; t < 4; t++) begin
          int r;
          r = n - 1 + t;
          if (r < 0) r = 0;             // R7
          if (r > rows - 1) r = rows - 1;
          s += pix(f, r, c) * wgt(ph, t);
        end
        exp_q.push_back(s);
      end
    end
    @(negedge clk);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        in_valid = 1; in_pix = 8'(pix(f, r, c));
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid idle", int'(out_valid), 0);

    run_frame(0, 8, 6, 6, 32'h0001_0000, "R3 unity");
    run_frame(1, 8, 6, 12, 32'h0000_8000, "R4 R7 R2 half step");
    run_frame(2, 8, 6, 7, 32'h0000_9FFF, "R5 R6 low fraction bits");
    run_frame(3, 8, 6, 3, 32'h0002_0000, "R9 step two");
    run_frame(4, 6, 6, 4, 32'h0003_0000, "R9 R7 past frame end");
    run_frame(5, 64, 5, 7, 32'h0000_B000, "R11 full width");
    run_frame(6, 1, 4, 3, 32'h0000_5000, "R11 R7 single column");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);   // R8: monitor flags any extra strobe
    check(in_ready == 1'b1, "R10 final re-arm", int'(in_ready), 1);
    check(exp_q.size() == 0, "R8 all rows emitted", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule